// File: doc/BRIEF.md
# Programmable cyclic code parity engine

This block computes a CRC syndrome, or the parity of a Fire-type cyclic code, over a stream of 24-bit words. The generator polynomial is set in software. The host writes the polynomial's lower coefficients into two tap registers and its degree into a degree register. The degree can be any value from 1 to 48. Up to degree 24 only the lower 24-bit shift register is used. Above 24, the lower register's top stage feeds the bottom stage of the upper register, so the two act as one 48-bit register.

Data words enter through a five-entry input queue with a valid/ready handshake. Once a start command has been given, the engine pulls words from that queue on its own and shifts each one in, most significant bit first, one bit per clock. No per-bit work is needed from the host.

A read command places the current syndrome in a five-entry output queue, which is drained with a valid/ready handshake. Each syndrome half is XORed with a mask register on the way out, which allows inverted-CRC conventions. A clear command zeroes the syndrome, flushes both queues and stops the engine.

Top module: `ccp_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `busy` and `deg_err` are 0.
- R2: Configuration is written through `cfg_we`/`cfg_addr`/`cfg_wdata`. Address 0 holds tap bits 23:0 and address 1 holds tap bits 47:24. Tap bit i is the coefficient of x^i for i below the degree, and the x^degree term is implied. Address 4 holds the degree. For a degree d of 24 or less, the engine computes the remainder of M(x)·x^d modulo the generator. Here M is the concatenated word stream, each word taken MSB first, and the shift register starts from zero after a clear. A read emits one word: the remainder, with bits at positions d and above equal to 0, XORed with the low mask at address 2.
- R3: For a degree from 25 to 48 the two registers act as one, and a read emits two words. The first is remainder bits 23:0 XORed with the low mask. The second is remainder bits 47:24 XORed with the high mask at address 3.
- R4: A degree write with a value outside 1..48 sets `deg_err` and leaves the degree in use unchanged. A later legal degree write clears `deg_err`.
- R5: Each input word taken by the engine holds `busy` high for exactly 24 consecutive cycles.
- R6: With five words in the input queue `in_ready` is 0. A word offered then is not stored and plays no part in any syndrome.
- R7: The output queue holds five words and presents them in order. While it is full, a pending syndrome word waits and is not lost. `out_data` stays stable while `out_valid` is high and `out_ready` is low.
- R8: A write to address 5 with bit 2 set (clear) zeroes the syndrome, empties both queues and stops the engine. Bit 0 in the same write (start) restarts it.
- R9: Words in the input queue are not processed until a start command, which is bit 0 of a write to address 5.
- R10: A read command (bit 1 of a write to address 5) given while a word is being shifted is held until that word is absorbed, and the result includes the whole word. A read does not alter the syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 24 | Configuration write data |
| in_valid | input | 1 | Input word offered |
| in_data | input | 24 | Input word |
| in_ready | output | 1 | Input queue can take a word |
| out_valid | output | 1 | Output queue has a word |
| out_data | output | 24 | Syndrome word at head of output queue |
| out_ready | input | 1 | Consumer takes the head word |
| busy | output | 1 | A word is being shifted in |
| deg_err | output | 1 | Last degree write was out of range |

## Verification
Two functions can collide in the same cycle: a syndrome read request and the bit-by-bit absorption of a word. The bench provokes this by issuing a read a few cycles after a word has been taken. It then judges the emitted syndrome against an arithmetically computed remainder of the complete word, and checks that a second read returns the same value. The second collision is a push offered to a full input queue. It is judged by the next syndrome, which must match a division over only the five accepted words. The remainder itself is checked across every degree from 1 to 48 by polynomial long division in the bench.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int WORD_W = 24;
    localparam int SR_W   = 2 * WORD_W;
    localparam int DEG_W  = 6;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TAP_LO = 3'd0,
        A_TAP_HI = 3'd1,
        A_MSK_LO = 3'd2,
        A_MSK_HI = 3'd3,
        A_DEG    = 3'd4,
        A_CMD    = 3'd5
    } cfg_addr_e;

    localparam int CMD_START = 0;
    localparam int CMD_READ  = 1;
    localparam int CMD_CLEAR = 2;

    typedef struct packed {
        logic start;
        logic read;
        logic clear;
    } cmd_t;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_LO   = 2'd1,
        EM_HI   = 2'd2
    } emit_st_e;

    // ones in the lowest d positions
    function automatic logic [SR_W-1:0] deg_mask(input logic [DEG_W-1:0] d);
        logic [SR_W:0] m;
        m = ((SR_W+1)'(1) << d) - (SR_W+1)'(1);
        return m[SR_W-1:0];
    endfunction

    // one Galois step of a divider whose feedback point is stage d-1
    function automatic logic [SR_W-1:0] lfsr_step(input logic [SR_W-1:0] cur,
                                                  input logic [SR_W-1:0] taps,
                                                  input logic [DEG_W-1:0] d,
                                                  input logic din);
        logic [SR_W-1:0] m;
        logic [SR_W-1:0] nxt;
        logic            fb;
        m   = deg_mask(d);
        fb  = din ^ cur[d - DEG_W'(1)];
        nxt = (cur << 1) & m;
        if (fb) nxt = nxt ^ (taps & m);
        return nxt;
    endfunction
endpackage

// File: rtl/ccp_fifo.sv
module ccp_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 5,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !rst && !clr) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/ccp_regs.sv
module ccp_regs
    import ccp_pkg::*;
#(
    parameter int DEF_DEG = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [SR_W-1:0]   taps,
    output logic [SR_W-1:0]   masks,
    output logic [DEG_W-1:0]  deg,
    output logic              deg_err,
    output cmd_t              cmd
);
    logic deg_ok;

    assign deg_ok = (wdata >= WORD_W'(1)) && (wdata <= WORD_W'(SR_W));

    always_comb begin
        cmd.start = we && (addr == A_CMD) && wdata[CMD_START];
        cmd.read  = we && (addr == A_CMD) && wdata[CMD_READ];
        cmd.clear = we && (addr == A_CMD) && wdata[CMD_CLEAR];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taps    <= '0;
            masks   <= '0;
            deg     <= DEG_W'(DEF_DEG);
            deg_err <= 1'b0;
        end else if (we) begin
            case (addr)
                A_TAP_LO: taps[WORD_W-1:0]     <= wdata;
                A_TAP_HI: taps[SR_W-1:WORD_W]  <= wdata;
                A_MSK_LO: masks[WORD_W-1:0]    <= wdata;
                A_MSK_HI: masks[SR_W-1:WORD_W] <= wdata;
                A_DEG: begin
                    if (deg_ok) begin
                        deg     <= wdata[DEG_W-1:0];
                        deg_err <= 1'b0;
                    end else begin
                        deg_err <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ccp_shifter.sv
module ccp_shifter
    import ccp_pkg::*;
#(
    localparam int CW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic [SR_W-1:0]   taps,
    input  logic [DEG_W-1:0]  deg,
    output logic [SR_W-1:0]   lfsr,
    output logic              busy
);
    logic [WORD_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic              act;

    assign busy = act;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lfsr <= '0;
            sh   <= '0;
            cnt  <= '0;
            act  <= 1'b0;
        end else if (load) begin
            sh  <= word;
            cnt <= '0;
            act <= 1'b1;
        end else if (act) begin
            lfsr <= lfsr_step(lfsr, taps, deg, sh[WORD_W-1]);
            sh   <= sh << 1;
            cnt  <= cnt + CW'(1);
            if (cnt == CW'(WORD_W - 1)) act <= 1'b0;
        end
    end
endmodule

// File: rtl/ccp_engine.sv
module ccp_engine
    import ccp_pkg::*;
#(
    parameter int DEPTH   = 5,
    parameter int DEF_DEG = 16,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              deg_err
);
    logic [SR_W-1:0]   taps, masks, lfsr;
    logic [DEG_W-1:0]  deg;
    cmd_t              cmd;
    logic [WORD_W-1:0] in_head, emit_word;
    logic              in_full, in_empty, out_full, out_empty;
    logic [CW-1:0]     in_cnt, out_cnt;
    logic              sh_busy, take, emit, joined;
    logic              run, pend;
    emit_st_e          st;

    ccp_regs #(.DEF_DEG(DEF_DEG)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .taps(taps), .masks(masks), .deg(deg), .deg_err(deg_err), .cmd(cmd)
    );

    ccp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_in_q (
        .clk(clk), .rst(rst), .clr(cmd.clear),
        .push(in_valid), .din(in_data), .pop(take), .dout(in_head),
        .full(in_full), .empty(in_empty), .count(in_cnt)
    );

    ccp_shifter u_shift (
        .clk(clk), .rst(rst), .clr(cmd.clear), .load(take), .word(in_head),
        .taps(taps), .deg(deg), .lfsr(lfsr), .busy(sh_busy)
    );

    ccp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_out_q (
        .clk(clk), .rst(rst), .clr(cmd.clear),
        .push(emit), .din(emit_word), .pop(out_ready), .dout(out_data),
        .full(out_full), .empty(out_empty), .count(out_cnt)
    );

    assign joined    = (deg > DEG_W'(WORD_W));
    assign in_ready  = !in_full;
    assign out_valid = !out_empty;
    assign busy      = sh_busy;

    assign take = (st == EM_IDLE) && !sh_busy && !pend && run && !in_empty && !cmd.clear;
    assign emit = ((st == EM_LO) || (st == EM_HI)) && !out_full && !cmd.clear;

    always_comb begin
        if (st == EM_HI) emit_word = lfsr[SR_W-1:WORD_W] ^ masks[SR_W-1:WORD_W];
        else             emit_word = lfsr[WORD_W-1:0]    ^ masks[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= EM_IDLE;
            pend <= 1'b0;
            run  <= 1'b0;
        end else if (cmd.clear) begin
            st   <= EM_IDLE;
            pend <= 1'b0;
            run  <= cmd.start;
        end else begin
            if (cmd.start) run <= 1'b1;
            pend <= pend | cmd.read;
            case (st)
                EM_IDLE: begin
                    if (!sh_busy && pend) begin
                        st   <= EM_LO;
                        pend <= cmd.read;
                    end
                end
                EM_LO: begin
                    if (!out_full) st <= joined ? EM_HI : EM_IDLE;
                end
                EM_HI: begin
                    if (!out_full) st <= EM_IDLE;
                end
                default: st <= EM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ccp_chk.sv
module ccp_chk
    import ccp_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_ready,
    input logic              busy,
    input logic              deg_err,
    input logic [CW-1:0]     in_cnt,
    input logic [DEG_W-1:0]  deg,
    input logic [SR_W-1:0]   lfsr
);
    logic       clr_w;
    logic [5:0] bcnt;

    assign clr_w = cfg_we && (cfg_addr == A_CMD) && cfg_wdata[CMD_CLEAR];

    always_ff @(posedge clk) begin
        if (rst || clr_w) bcnt <= '0;
        else              bcnt <= busy ? bcnt + 6'd1 : 6'd0;
    end

    // R6
    refused_push_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> (in_cnt <= $past(in_cnt)));

    // R6
    in_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_cnt <= CW'(DEPTH));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bcnt <= 6'd23));

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(clr_w)) |-> ($past(bcnt) == 6'd23));

    // R4
    deg_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (deg >= DEG_W'(1)) && (deg <= DEG_W'(SR_W)));

    // R4
    deg_err_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(deg_err) |-> $past(cfg_we && (cfg_addr == A_DEG)));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_w) |-> (!out_valid && in_ready && (lfsr == '0)));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !clr_w) |=> (out_valid && $stable(out_data)));
endmodule

bind ccp_engine ccp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .busy(busy), .deg_err(deg_err), .in_cnt(in_cnt),
    .deg(deg), .lfsr(lfsr)
);

// File: tb/tb_ccp_engine.sv
`timescale 1ns/1ps
module tb_ccp_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [23:0] cfg_wdata = 24'd0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = 24'd0;
    logic        in_ready, out_valid, busy, deg_err;
    logic [23:0] out_data;
    logic        out_ready = 1'b1;

    always #5 clk = ~clk;

    ccp_engine dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .deg_err(deg_err)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [23:0] obuf [64];
    int          ocnt = 0;
    int          bcnt = 0;
    int          blast = 0;
    logic [23:0] msg [8];
    bit          ok;
    bit          oks [6];
    logic [47:0] expv, t;

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (ocnt < 64) obuf[ocnt] = out_data;
            ocnt++;
        end
        if (busy) bcnt++;
        else begin
            if (bcnt != 0) blast = bcnt;
            bcnt = 0;
        end
    end

    task automatic chk(input bit c, input string r, input logic [47:0] a, input logic [47:0] e);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, a, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [23:0] d, output bit acc);
        @(negedge clk);
        acc = in_ready; in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk);
        #1 out_ready = v;
    endtask

    // long division of (message * x^d) by x^d + taps
    function automatic logic [47:0] ref_crc(input logic [47:0] tp, input int d, input int n);
        logic [48:0] rem, g;
        rem = '0;
        g = (49'd1 << d) | ({1'b0, tp} & ((49'd1 << d) - 49'd1));
        for (int i = 0; i < n; i++) begin
            for (int b = 23; b >= 0; b--) begin
                rem = (rem << 1) | {48'd0, msg[i][b]};
                if (rem[d]) rem = rem ^ g;
            end
        end
        for (int z = 0; z < d; z++) begin
            rem = rem << 1;
            if (rem[d]) rem = rem ^ g;
        end
        return rem[47:0];
    endfunction

    task automatic cfg(input logic [47:0] tp, input int d, input logic [23:0] mlo, input logic [23:0] mhi);
        wr(3'd0, tp[23:0]); wr(3'd1, tp[47:24]);
        wr(3'd2, mlo); wr(3'd3, mhi);
        wr(3'd4, 24'(d));
    endtask

    task automatic proc(input int n, input logic [2:0] cmdbits);
        wr(3'd5, {21'd0, cmdbits});
        ocnt = 0;
        for (int i = 0; i < n; i++) push(msg[i], ok);
        idle(n * 26 + 4);
        wr(3'd5, 24'd2);
        idle(6);
    endtask

    task automatic judge(input string r, input logic [47:0] tp, input int d, input int n,
                         input logic [23:0] mlo, input logic [23:0] mhi);
        logic [47:0] e;
        e = ref_crc(tp, d, n);
        chk(ocnt == ((d > 24) ? 2 : 1), r, 48'(ocnt), 48'((d > 24) ? 2 : 1));
        chk(obuf[0] == (e[23:0] ^ mlo), r, {24'd0, obuf[0]}, {24'd0, e[23:0] ^ mlo});
        if (d > 24)
            chk(obuf[1] == (e[47:24] ^ mhi), r, {24'd0, obuf[1]}, {24'd0, e[47:24] ^ mhi});
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", {47'd0, in_ready}, 48'd1);
        chk(out_valid == 1'b0, "R1 out_valid", {47'd0, out_valid}, 48'd0);
        chk(busy == 1'b0, "R1 busy", {47'd0, busy}, 48'd0);
        chk(deg_err == 1'b0, "R1 deg_err", {47'd0, deg_err}, 48'd0);

        // R2 / R3 sweep of every degree
        for (int d = 1; d <= 48; d++) begin
            logic [47:0] dm;
            dm = (48'd1 << d) - 48'd1;
            t = ((48'hA5C396E17B2D ^ (48'(d) * 48'h9E3779B9)) & dm) | 48'd1;
            msg[0] = 24'hC0FFEE ^ 24'(d * 977);
            msg[1] = 24'h13579B + 24'(d);
            cfg(t, d, 24'd0, 24'd0);
            proc(2, 3'b101);
            judge((d > 24) ? "R3 sweep" : "R2 sweep", t, d, 2, 24'd0, 24'd0);
        end

        // R2 with mask, 16-bit polynomial, three words
        msg[0] = 24'h123456; msg[1] = 24'hFEDCBA; msg[2] = 24'h000001;
        cfg(48'h8005, 16, 24'hFFFFFF, 24'd0);
        proc(3, 3'b101);
        judge("R2 mask", 48'h8005, 16, 3, 24'hFFFFFF, 24'd0);
        // R5 busy length of last word
        chk(blast == 24, "R5 busy cycles", 48'(blast), 48'd24);

        // R3 with masks, degree 40
        t = 48'h00_8C_3A_11_F0_07;
        cfg(t, 40, 24'hA5A5A5, 24'h3C3C3C);
        proc(1, 3'b101);
        judge("R3 mask", t, 40, 1, 24'hA5A5A5, 24'h3C3C3C);

        // R4 illegal degrees keep the previous one
        t = 48'h0B_C4_9F;
        cfg(t, 20, 24'd0, 24'd0);
        wr(3'd4, 24'd0);
        chk(deg_err == 1'b1, "R4 deg 0", {47'd0, deg_err}, 48'd1);
        wr(3'd4, 24'd49);
        chk(deg_err == 1'b1, "R4 deg 49", {47'd0, deg_err}, 48'd1);
        msg[0] = 24'h9A0F31;
        proc(1, 3'b101);
        judge("R4 degree kept", t, 20, 1, 24'd0, 24'd0);
        chk(deg_err == 1'b1, "R4 flag held", {47'd0, deg_err}, 48'd1);
        wr(3'd4, 24'd33);
        chk(deg_err == 1'b0, "R4 legal clears", {47'd0, deg_err}, 48'd0);

        // R6 full input queue refuses the sixth word
        t = 48'h00_01_A3_5D;
        cfg(t, 24, 24'd0, 24'd0);
        wr(3'd5, 24'd4);
        for (int i = 0; i < 5; i++) msg[i] = 24'h4D2 * 24'(i + 3) ^ 24'h5A0000;
        for (int i = 0; i < 5; i++) begin push(msg[i], ok); oks[i] = ok; end
        chk(in_ready == 1'b0, "R6 ready low", {47'd0, in_ready}, 48'd0);
        push(24'hDEAD01, ok); oks[5] = ok;
        chk(oks[0] && oks[1] && oks[2] && oks[3] && oks[4], "R6 five taken",
            {47'd0, oks[4]}, 48'd1);
        chk(oks[5] == 1'b0, "R6 sixth refused", {47'd0, oks[5]}, 48'd0);
        ocnt = 0;
        wr(3'd5, 24'd1);
        idle(5 * 26 + 4);
        wr(3'd5, 24'd2);
        idle(6);
        judge("R6 syndrome", t, 24, 5, 24'd0, 24'd0);

        // R9 no processing before start
        t = 48'h00_00_0C_A7;
        cfg(t, 12, 24'd0, 24'd0);
        wr(3'd5, 24'd4);
        msg[0] = 24'h7E81C3;
        push(msg[0], ok);
        idle(40);
        chk(busy == 1'b0, "R9 idle busy", {47'd0, busy}, 48'd0);
        ocnt = 0;
        wr(3'd5, 24'd2);
        idle(6);
        chk(ocnt == 1 && obuf[0] == 24'd0, "R9 no progress", {24'd0, obuf[0]}, 48'd0);
        ocnt = 0;
        wr(3'd5, 24'd1);
        idle(30);
        wr(3'd5, 24'd2);
        idle(6);
        judge("R9 after start", t, 12, 1, 24'd0, 24'd0);

        // R7 output queue full: six words from three reads
        t = 48'h00_00_2E_6B_B4_01;
        cfg(t, 30, 24'd0, 24'd0);
        msg[0] = 24'h0BADF0;
        wr(3'd5, 24'd5);
        push(msg[0], ok);
        idle(30);
        set_ready(1'b0);
        ocnt = 0;
        for (int k = 0; k < 3; k++) begin wr(3'd5, 24'd2); idle(4); end
        idle(10);
        chk(out_valid == 1'b1 && ocnt == 0, "R7 held", {47'd0, out_valid}, 48'd1);
        set_ready(1'b1);
        idle(12);
        expv = ref_crc(t, 30, 1);
        chk(ocnt == 6, "R7 count", 48'(ocnt), 48'd6);
        for (int k = 0; k < 3; k++) begin
            chk(obuf[2*k] == expv[23:0], "R7 order lo", {24'd0, obuf[2*k]}, {24'd0, expv[23:0]});
            chk(obuf[2*k+1] == expv[47:24], "R7 order hi", {24'd0, obuf[2*k+1]}, {24'd0, expv[47:24]});
        end

        // R8 clear flushes output queue and zeroes syndrome
        set_ready(1'b0);
        wr(3'd5, 24'd2);
        idle(8);
        chk(out_valid == 1'b1, "R8 setup", {47'd0, out_valid}, 48'd1);
        wr(3'd5, 24'd4);
        chk(out_valid == 1'b0, "R8 out flushed", {47'd0, out_valid}, 48'd0);
        chk(in_ready == 1'b1, "R8 in empty", {47'd0, in_ready}, 48'd1);
        set_ready(1'b1);
        idle(4);
        ocnt = 0;
        wr(3'd5, 24'd2);
        idle(6);
        chk(ocnt == 2 && obuf[0] == 24'd0 && obuf[1] == 24'd0, "R8 zero syndrome",
            {obuf[1], obuf[0]}, 48'd0);
        msg[0] = 24'h55AA0F;
        proc(1, 3'b001);
        judge("R8 fresh start", t, 30, 1, 24'd0, 24'd0);

        // R10 read during shifting is deferred and leaves the syndrome alone
        t = 48'h00_0E_90_3D;
        cfg(t, 20, 24'd0, 24'd0);
        wr(3'd5, 24'd5);
        ocnt = 0;
        msg[0] = 24'hF00F5A;
        push(msg[0], ok);
        idle(5);
        chk(busy == 1'b1, "R10 busy at read", {47'd0, busy}, 48'd1);
        wr(3'd5, 24'd2);
        idle(30);
        judge("R10 deferred", t, 20, 1, 24'd0, 24'd0);
        wr(3'd5, 24'd2);
        idle(6);
        chk(ocnt == 2 && obuf[1] == obuf[0], "R10 read repeat", {24'd0, obuf[1]}, {24'd0, obuf[0]});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule